// File: doc/BRIEF.md
# Debounced BCD Up/Down Setpoint

The block keeps a two-digit decimal setpoint, 00 to 99, held as packed BCD, for use as the duty value of a pulse-width comparator. Two mechanical push buttons, one to raise the value and one to lower it, are the only operator inputs. Each button is brought into the clock domain and filtered, so that one press, however much the contact chatters, moves the setpoint by exactly one.

The value is held in decimal decades chained by carry and borrow. The filtered press drives the units decade. A units wrap, 9 to 0 going up or 0 to 9 going down, steps the tens decade in the same clock. A one-cycle strobe marks every clock in which the value changes. Segment decoding and the comparison against the period counter belong to other blocks.

Top module: `duty_setpoint`

## Requirements
- R1: While rst_ni is low, and after it is released, setpoint_o reads 8'h00 and step_o is low until the first accepted press.
- R2: An accepted press of inc_btn_i raises the setpoint by one in decimal. setpoint_o[3:0] holds the units digit and setpoint_o[7:4] holds the tens digit, so 09 goes to 10.
- R3: An accepted press of dec_btn_i lowers the setpoint by one in decimal, so 10 goes to 09.
- R4: Raising 99 gives 00, with both digits changing in the same clock.
- R5: Lowering 00 gives 99, with both digits changing in the same clock.
- R6: A button level that lasts fewer than STABLE_CYCLES clocks is ignored. A press whose contact bounces before it settles gives exactly one step.
- R7: Holding a button down gives one step and no repeats. Releasing it gives no step.
- R8: If the raise and lower presses are accepted in the same clock, the setpoint stays unchanged and step_o stays low.
- R9: step_o is high for exactly one clock, in the first clock that shows the new setpoint. The setpoint never changes without step_o.
- R10: Each nibble of setpoint_o is always a valid decimal digit, 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_btn_i | input | 1 | Raw raise button, active high, asynchronous |
| dec_btn_i | input | 1 | Raw lower button, active high, asynchronous |
| setpoint_o | output | 8 | Setpoint, packed BCD, tens digit in the upper nibble |
| step_o | output | 1 | One-clock strobe marking a setpoint change |

## Verification
The hardest case to reach is two presses accepted in the same clock. Buttons are asynchronous and pass through independent filters, so the bench must drive both raw inputs with exactly the same edges, down to the clock. Only then do both filters accept on the same cycle. Wraps in both directions are reached by walking the whole 100-value ring up and then down. Some presses in that walk have short chatter bursts on press and release, to show that each still counts once.

// File: rtl/setpoint_pkg.sv
package setpoint_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t BCD_MIN = 4'd0;
  localparam bcd_digit_t BCD_MAX = 4'd9;
endpackage

// File: rtl/key_filter.sv
module key_filter #(
  parameter int unsigned STABLE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic press_o
);
  localparam int unsigned CNT_W = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

  logic             sync1_q, sync2_q;
  logic             level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ, accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
    end
  end

  assign differ = sync2_q != level_q;
  assign accept = differ && (cnt_q == CNT_LAST);

  // filtered level moves only after STABLE_CYCLES equal samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!differ) begin
      cnt_q   <= '0;
    end else if (accept) begin
      level_q <= sync2_q;
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // rising edge of the filtered level
  assign press_o = accept && sync2_q;
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import setpoint_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       up_i,
  output bcd_digit_t digit_o,
  output logic       wrap_o
);
  bcd_digit_t digit_q, digit_d;

  always_comb begin
    if (up_i) digit_d = (digit_q == BCD_MAX) ? BCD_MIN : digit_q + 4'd1;
    else      digit_d = (digit_q == BCD_MIN) ? BCD_MAX : digit_q - 4'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   digit_q <= BCD_MIN;
    else if (en_i) digit_q <= digit_d;
  end

  assign digit_o = digit_q;
  assign wrap_o  = en_i && (up_i ? (digit_q == BCD_MAX) : (digit_q == BCD_MIN));
endmodule

// File: rtl/duty_setpoint.sv
module duty_setpoint
  import setpoint_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 1000,
  parameter int unsigned DIGITS        = 2,
  localparam int unsigned SP_W         = DIGITS * DIGIT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_btn_i,
  input  logic            dec_btn_i,
  output logic [SP_W-1:0] setpoint_o,
  output logic            step_o
);
  logic            inc_pulse, dec_pulse, apply;
  logic [DIGITS:0] chain;
  logic            step_q;

  key_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_inc_filter (
    .clk_i, .rst_ni, .raw_i(inc_btn_i), .press_o(inc_pulse)
  );
  key_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_dec_filter (
    .clk_i, .rst_ni, .raw_i(dec_btn_i), .press_o(dec_pulse)
  );

  // coincident presses cancel
  assign apply    = inc_pulse ^ dec_pulse;
  assign chain[0] = apply;

  for (genvar g = 0; g < DIGITS; g++) begin : g_decade
    bcd_decade u_decade (
      .clk_i,
      .rst_ni,
      .en_i   (chain[g]),
      .up_i   (inc_pulse),
      .digit_o(setpoint_o[g*DIGIT_W +: DIGIT_W]),
      .wrap_o (chain[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 1'b0;
    else         step_q <= apply;
  end

  assign step_o = step_q;
endmodule

// File: rtl/duty_setpoint_chk.sv
module duty_setpoint_chk #(
  parameter int unsigned DIGITS = 2,
  localparam int unsigned SP_W  = DIGITS * 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [SP_W-1:0] setpoint_o,
  input logic            step_o,
  input logic            inc_pulse,
  input logic            dec_pulse,
  input logic            ring_wrap
);
  localparam int MODULUS = 10 ** DIGITS;

  function automatic int to_int(logic [SP_W-1:0] v);
    int r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic all_decimal(logic [SP_W-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r10_digits_decimal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_decimal(setpoint_o));

  a_r9_change_has_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setpoint_o != $past(setpoint_o)) |-> step_o);

  a_r9_step_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  a_r2_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> ((to_int(setpoint_o) == (to_int($past(setpoint_o)) + 1) % MODULUS) ||
                (to_int(setpoint_o) == (to_int($past(setpoint_o)) + MODULUS - 1) % MODULUS)));

  a_r8_conflict_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_pulse && dec_pulse) |=> (!step_o && $stable(setpoint_o)));

  a_r4_r5_ring_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_wrap |=> (to_int(setpoint_o) == 0 || to_int(setpoint_o) == MODULUS - 1));
endmodule

bind duty_setpoint duty_setpoint_chk #(.DIGITS(DIGITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .setpoint_o(setpoint_o),
  .step_o    (step_o),
  .inc_pulse (inc_pulse),
  .dec_pulse (dec_pulse),
  .ring_wrap (chain[DIGITS])
);

// File: tb/duty_setpoint_bench.sv
module duty_setpoint_bench;
  localparam int STABLE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inc_btn = 1'b0;
  logic       dec_btn = 1'b0;
  logic [7:0] setpoint;
  logic       step;

  int tests = 0;
  int fails = 0;
  int model = 0;
  int step_total = 0;
  logic step_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  duty_setpoint #(.STABLE_CYCLES(STABLE), .DIGITS(2)) u_duty_setpoint (
    .clk_i(clk), .rst_ni(rst_n), .inc_btn_i(inc_btn), .dec_btn_i(dec_btn),
    .setpoint_o(setpoint), .step_o(step)
  );

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(string req, int actual, int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  // step monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (step && step_prev) begin
        tests++; fails++;
        $display("FAIL R9: step high two cycles, actual 1 expected 0");
      end
      if (step) step_total++;
      step_prev = step;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // which: 0 inc, 1 dec, 2 both together
  task automatic drive(int which, logic v);
    if (which != 1) inc_btn = v;
    if (which != 0) dec_btn = v;
  endtask

  task automatic press(int which, bit bouncy);
    if (bouncy)
      for (int b = 0; b < 3; b++) begin
        drive(which, 1'b1); idle(2); drive(which, 1'b0); idle(1);
      end
    drive(which, 1'b1);
    idle(STABLE + 30);
    if (bouncy)
      for (int b = 0; b < 3; b++) begin
        drive(which, 1'b0); idle(2); drive(which, 1'b1); idle(1);
      end
    drive(which, 1'b0);
    idle(STABLE + 10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s0;
    idle(3);
    check("R1 reset value", int'(setpoint), 0);
    check("R1 reset step", int'(step), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(5);
    check("R1 after release", int'(setpoint), 0);
    check("R1 no step", step_total, 0);

    // R6: short glitches alone are ignored
    for (int g = 0; g < 4; g++) begin
      inc_btn = 1'b1; idle(STABLE - 3); inc_btn = 1'b0; idle(STABLE);
    end
    idle(STABLE + 5);
    check("R6 glitch ignored value", int'(setpoint), 0);
    check("R6 glitch ignored steps", step_total, 0);

    // R2 R4 R6 R7: full upward ring, some presses bouncy
    for (int i = 0; i < 100; i++) begin
      s0 = step_total;
      press(0, (i % 3) == 0);
      model = (model + 1) % 100;
      check((i == 99) ? "R4 wrap up" : "R2 increment", int'(setpoint), int'(to_bcd(model)));
      check("R6 R7 one step per press", step_total - s0, 1);
      check("R10 units digit", int'(setpoint[3:0] <= 4'd9), 1);
    end

    // R3 R5: full downward ring
    for (int i = 0; i < 100; i++) begin
      s0 = step_total;
      press(1, (i % 4) == 1);
      model = (model + 99) % 100;
      check((i == 0) ? "R5 wrap down" : "R3 decrement", int'(setpoint), int'(to_bcd(model)));
      check("R6 R7 one step per press", step_total - s0, 1);
      check("R10 tens digit", int'(setpoint[7:4] <= 4'd9), 1);
    end

    // R7: long hold, no repeat, release silent
    s0 = step_total;
    inc_btn = 1'b1; idle(STABLE * 20);
    model = (model + 1) % 100;
    check("R7 hold one step", step_total - s0, 1);
    inc_btn = 1'b0; idle(STABLE * 4);
    check("R7 release silent", step_total - s0, 1);
    check("R7 value", int'(setpoint), int'(to_bcd(model)));

    // R8: identical presses on both buttons cancel
    for (int k = 0; k < 3; k++) begin
      s0 = step_total;
      press(2, k == 1);
      check("R8 both pressed value", int'(setpoint), int'(to_bcd(model)));
      check("R8 both pressed no step", step_total - s0, 0);
    end

    // R9: step coincides with first cycle of new value
    inc_btn = 1'b1;
    s0 = int'(setpoint);
    while (int'(setpoint) == s0) @(negedge clk);
    check("R9 step with new value", int'(step), 1);
    @(negedge clk);
    check("R9 step dropped", int'(step), 0);
    inc_btn = 1'b0; idle(STABLE + 10);

    finish_run();
  end
endmodule